// File: doc/BRIEF.md
# Serial Configuration Port With Trailing-Bit Routing

This block takes configuration words over three slow wires: a serial clock, a data line and a load strobe. All three are sampled in the system clock domain. Each rising edge of the serial clock shifts one data bit into a 19-bit shift register, most significant bit first. A rising edge of the load strobe moves the collected word into one of two holding registers. The last bit received picks which one.

A word that ends in 1 is a reference word. It holds a prescaler-select flag and a 14-bit reference ratio. Only its lowest 16 received bits are used. A word that ends in 0 is a feedback word. It holds an 11-bit main ratio and a 7-bit swallow ratio. A reference ratio below the minimum is refused: the stored values stay as they were, and an error flag is raised. Every accepted transfer is reported with a one-cycle strobe. The fields are presented as parallel outputs to the divider logic around the block.

Top module: `sercfg_port`

## Requirements
- R1: After reset, `ref_ratio` is 8 and `presc_sel`, `main_ratio`, `swallow_ratio`, `ref_err` and `load_strobe` are all 0.
- R2: One bit is shifted on each rising edge of `ser_clk`, and a falling edge shifts nothing. The last bit shifted is bit 0 of the word, and earlier bits sit at higher positions.
- R3: When bit 0 of the word is 1 and the ratio is accepted, the reference fields are updated. `presc_sel` takes word bit 15 and `ref_ratio` takes word bits 14..1. Word bits 18..16 are ignored, and the feedback fields keep their values.
- R4: When bit 0 of the word is 0, the feedback fields are updated. `main_ratio` takes word bits 18..8 and `swallow_ratio` takes word bits 7..1. The reference fields keep their values.
- R5: A transfer happens only on a rising edge of `ser_load`. Holding the line high gives exactly one transfer. A line that is already high when reset is released gives no transfer, because the load line is taken as idle-high.
- R6: `load_strobe` is high for exactly one cycle for each accepted transfer. It rises in the cycle in which the new field values first appear.
- R7: A reference word whose ratio is below 8 changes no field and gives no strobe, and it sets `ref_err`. `ref_err` stays set through feedback transfers and is cleared by the next accepted reference word. A ratio of exactly 8 is accepted.
- R8: When a rising edge of `ser_clk` and a rising edge of `ser_load` are detected in the same system cycle, the transferred word includes the bit shifted at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Load strobe, idle high, acts on its rising edge |
| presc_sel | output | 1 | Prescaler-select flag from the reference word |
| ref_ratio | output | 14 | Reference divide ratio |
| main_ratio | output | 11 | Main feedback divide ratio |
| swallow_ratio | output | 7 | Swallow divide ratio |
| load_strobe | output | 1 | One-cycle pulse on each accepted transfer |
| ref_err | output | 1 | A reference ratio below the minimum was refused |

## Verification
The shift of the final bit and the load transfer can land in the same system cycle. The bench provokes this by raising `ser_clk` and `ser_load` together on the last bit of a word. It picks the next-to-last bit so that a transfer of the word without the new bit would end with the opposite control value. Such a transfer would go to the wrong destination, so the expected fields and the strobe order in the scoreboard decide whether the new bit was included.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  // Default field widths of the two configuration words
  localparam int DEF_REF_RATIO_W = 14;
  localparam int DEF_MAIN_W      = 11;
  localparam int DEF_SWAL_W      = 7;
  localparam int DEF_MIN_REF     = 8;
  localparam int DEF_SYNC_STAGES = 2;

  // Outcome of a load edge
  typedef enum logic [1:0] {
    RT_NONE   = 2'd0,
    RT_REF    = 2'd1,
    RT_FB     = 2'd2,
    RT_REJECT = 2'd3
  } route_t;

endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sercfg_shift.sv
module sercfg_shift #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word_q,
  output logic [W-1:0] word_nxt
);

  // The new bit enters at position 0, so the first bit sent ends up highest.
  always_comb begin
    word_nxt = word_q;
    if (shift_en) begin
      word_nxt = {word_q[W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (shift_en) begin
      word_q <= word_nxt;
    end
  end

endmodule

// File: rtl/sercfg_route.sv
module sercfg_route
  import sercfg_pkg::*;
#(
  parameter int REF_RATIO_W = DEF_REF_RATIO_W,
  parameter int MAIN_W      = DEF_MAIN_W,
  parameter int SWAL_W      = DEF_SWAL_W,
  parameter int MIN_REF     = DEF_MIN_REF,
  parameter int SH_W        = 1 + MAIN_W + SWAL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_edge,
  input  logic [SH_W-1:0]        word,
  output logic                   presc_sel,
  output logic [REF_RATIO_W-1:0] ref_ratio,
  output logic [MAIN_W-1:0]      main_ratio,
  output logic [SWAL_W-1:0]      swallow_ratio,
  output logic                   load_strobe,
  output logic                   ref_err
);

  localparam int REF_WORD_W = REF_RATIO_W + 2;
  localparam logic [REF_RATIO_W-1:0] MIN_REF_V = REF_RATIO_W'(MIN_REF);

  route_t                 route;
  logic                   ctrl_bit;
  logic                   cand_presc;
  logic [REF_RATIO_W-1:0] cand_ratio;
  logic [MAIN_W-1:0]      cand_main;
  logic [SWAL_W-1:0]      cand_swal;

  logic                   presc_d;
  logic [REF_RATIO_W-1:0] ratio_d;
  logic [MAIN_W-1:0]      main_d;
  logic [SWAL_W-1:0]      swal_d;
  logic                   strobe_d;
  logic                   err_d;

  // Field extraction and route decision
  always_comb begin
    ctrl_bit   = word[0];
    cand_presc = word[REF_WORD_W-1];
    cand_ratio = word[REF_RATIO_W:1];
    cand_main  = word[SH_W-1:SWAL_W+1];
    cand_swal  = word[SWAL_W:1];
    route      = RT_NONE;
    if (load_edge) begin
      if (ctrl_bit) begin
        route = (cand_ratio >= MIN_REF_V) ? RT_REF : RT_REJECT;
      end else begin
        route = RT_FB;
      end
    end
  end

  // Next state of the holding registers
  always_comb begin
    presc_d  = presc_sel;
    ratio_d  = ref_ratio;
    main_d   = main_ratio;
    swal_d   = swallow_ratio;
    err_d    = ref_err;
    strobe_d = 1'b0;
    case (route)
      RT_REF: begin
        presc_d  = cand_presc;
        ratio_d  = cand_ratio;
        err_d    = 1'b0;
        strobe_d = 1'b1;
      end
      RT_FB: begin
        main_d   = cand_main;
        swal_d   = cand_swal;
        strobe_d = 1'b1;
      end
      RT_REJECT: begin
        err_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_sel     <= 1'b0;
      ref_ratio     <= MIN_REF_V;
      main_ratio    <= '0;
      swallow_ratio <= '0;
      load_strobe   <= 1'b0;
      ref_err       <= 1'b0;
    end else begin
      presc_sel     <= presc_d;
      ref_ratio     <= ratio_d;
      main_ratio    <= main_d;
      swallow_ratio <= swal_d;
      load_strobe   <= strobe_d;
      ref_err       <= err_d;
    end
  end

endmodule

// File: rtl/sercfg_port.sv
module sercfg_port
  import sercfg_pkg::*;
#(
  parameter int REF_RATIO_W = DEF_REF_RATIO_W,
  parameter int MAIN_W      = DEF_MAIN_W,
  parameter int SWAL_W      = DEF_SWAL_W,
  parameter int MIN_REF     = DEF_MIN_REF,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk,
  input  logic                   ser_data,
  input  logic                   ser_load,
  output logic                   presc_sel,
  output logic [REF_RATIO_W-1:0] ref_ratio,
  output logic [MAIN_W-1:0]      main_ratio,
  output logic [SWAL_W-1:0]      swallow_ratio,
  output logic                   load_strobe,
  output logic                   ref_err
);

  localparam int SH_W = 1 + MAIN_W + SWAL_W;

  logic [1:0]      clkdat_s;
  logic            load_s;
  logic            clk_prev_q, clk_prev_d;
  logic            load_prev_q, load_prev_d;
  logic            shift_edge;
  logic            load_edge;
  logic [SH_W-1:0] word_q;
  logic [SH_W-1:0] word_nxt;

  // Serial clock and data travel through the same stages
  sercfg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_cd (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_clk, ser_data}),
    .q     (clkdat_s)
  );

  // The load line is taken as idle-high: a level already high gives no edge
  sercfg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ld (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ser_load),
    .q     (load_s)
  );

  always_comb begin
    clk_prev_d  = clkdat_s[1];
    load_prev_d = load_s;
    shift_edge  = clkdat_s[1] & ~clk_prev_q;
    load_edge   = load_s & ~load_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q  <= 1'b0;
      load_prev_q <= 1'b1;
    end else begin
      clk_prev_q  <= clk_prev_d;
      load_prev_q <= load_prev_d;
    end
  end

  sercfg_shift #(.W(SH_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_edge),
    .bit_in   (clkdat_s[0]),
    .word_q   (word_q),
    .word_nxt (word_nxt)
  );

  // The route stage sees the word with this cycle's bit already in place
  sercfg_route #(
    .REF_RATIO_W (REF_RATIO_W),
    .MAIN_W      (MAIN_W),
    .SWAL_W      (SWAL_W),
    .MIN_REF     (MIN_REF),
    .SH_W        (SH_W)
  ) u_route (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_edge     (load_edge),
    .word          (word_nxt),
    .presc_sel     (presc_sel),
    .ref_ratio     (ref_ratio),
    .main_ratio    (main_ratio),
    .swallow_ratio (swallow_ratio),
    .load_strobe   (load_strobe),
    .ref_err       (ref_err)
  );

endmodule

// File: rtl/sercfg_port_chk.sv
module sercfg_port_chk #(
  parameter int REF_RATIO_W = 14,
  parameter int MAIN_W      = 11,
  parameter int SWAL_W      = 7,
  parameter int MIN_REF     = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   load_edge,
  input logic                   presc_sel,
  input logic [REF_RATIO_W-1:0] ref_ratio,
  input logic [MAIN_W-1:0]      main_ratio,
  input logic [SWAL_W-1:0]      swallow_ratio,
  input logic                   load_strobe,
  input logic                   ref_err
);

  // R6: the strobe never lasts two cycles
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> !load_strobe);

  // R5: a strobe is always caused by a detected load edge
  assert_strobe_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> $past(load_edge));

  // R5: without a load edge every held field keeps its value
  assert_hold_no_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_edge |=> $stable({presc_sel, ref_ratio, main_ratio, swallow_ratio, ref_err}));

  // R7: the stored reference ratio never falls below the minimum
  assert_ref_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ratio >= REF_RATIO_W'(MIN_REF));

  // R7: a refusal raises the error flag without a strobe or a field change
  assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_err) |-> (!load_strobe && $stable(ref_ratio) && $stable(presc_sel)));

endmodule

bind sercfg_port sercfg_port_chk #(
  .REF_RATIO_W (REF_RATIO_W),
  .MAIN_W      (MAIN_W),
  .SWAL_W      (SWAL_W),
  .MIN_REF     (MIN_REF)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .load_edge     (load_edge),
  .presc_sel     (presc_sel),
  .ref_ratio     (ref_ratio),
  .main_ratio    (main_ratio),
  .swallow_ratio (swallow_ratio),
  .load_strobe   (load_strobe),
  .ref_err       (ref_err)
);

// File: tb/sercfg_port_bench.sv
module sercfg_port_bench;

  typedef struct packed {
    logic        presc;
    logic [13:0] ref_r;
    logic [10:0] main_r;
    logic [6:0]  swal_r;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        ser_clk;
  logic        ser_data;
  logic        ser_load;
  logic        presc_sel;
  logic [13:0] ref_ratio;
  logic [10:0] main_ratio;
  logic [6:0]  swallow_ratio;
  logic        load_strobe;
  logic        ref_err;

  int    n_checks;
  int    n_fails;
  int    n_strobes;
  int    exp_strobes;
  bit    done;
  logic  prev_strobe;
  item_t exp_q[$];

  // Bench model of the held state
  item_t model;
  logic  model_err;

  sercfg_port u_sercfg_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_clk       (ser_clk),
    .ser_data      (ser_data),
    .ser_load      (ser_load),
    .presc_sel     (presc_sel),
    .ref_ratio     (ref_ratio),
    .main_ratio    (main_ratio),
    .swallow_ratio (swallow_ratio),
    .load_strobe   (load_strobe),
    .ref_err       (ref_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop the expected item on every strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (load_strobe) begin
        n_strobes++;
        check(!prev_strobe, "R6 strobe width one cycle", 64'(prev_strobe), 64'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 strobe with no transfer expected", 64'd1, 64'd0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check({presc_sel, ref_ratio, main_ratio, swallow_ratio} == e,
                "R6 fields at strobe", 64'({presc_sel, ref_ratio, main_ratio, swallow_ratio}),
                64'(e));
        end
      end
      prev_strobe <= load_strobe;
    end else begin
      prev_strobe <= 1'b0;
    end
  end

  task automatic check_all(input string tag);
    check({presc_sel, ref_ratio, main_ratio, swallow_ratio} == model, tag,
          64'({presc_sel, ref_ratio, main_ratio, swallow_ratio}), 64'(model));
    check(ref_err == model_err, {tag, " err flag"}, 64'(ref_err), 64'(model_err));
  endtask

  // Shift n bits MSB first. The data line flips on each falling edge (R2).
  // With coinc set, the last rising clock edge and the load edge coincide (R8).
  task automatic send_bits(input logic [18:0] w, input int n, input bit coinc,
                           input int hold);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      wait_cyc(4);
      ser_clk = 1'b1;
      if (i == 0 && coinc) ser_load = 1'b1;
      wait_cyc(4);
      ser_clk  = 1'b0;
      ser_data = ~w[i];
      wait_cyc(4);
    end
    if (!coinc) begin
      ser_load = 1'b1;
    end
    wait_cyc(hold);
    ser_load = 1'b0;
    wait_cyc(8);
  endtask

  task automatic ref_word(input logic presc, input logic [13:0] ratio,
                          input bit coinc, input int hold, input string tag);
    if (ratio >= 14'd8) begin
      model.presc = presc;
      model.ref_r = ratio;
      model_err   = 1'b0;
      exp_q.push_back(model);
      exp_strobes++;
    end else begin
      model_err = 1'b1;
    end
    send_bits({3'b000, presc, ratio, 1'b1}, 16, coinc, hold);
    check_all(tag);
  endtask

  task automatic fb_word(input logic [10:0] m, input logic [6:0] s,
                         input bit coinc, input int hold, input string tag);
    model.main_r = m;
    model.swal_r = s;
    exp_q.push_back(model);
    exp_strobes++;
    send_bits({m, s, 1'b0}, 19, coinc, hold);
    check_all(tag);
  endtask

  initial begin
    n_checks    = 0;
    n_fails     = 0;
    n_strobes   = 0;
    exp_strobes = 0;
    done        = 1'b0;
    rst_n       = 1'b0;
    ser_clk     = 1'b0;
    ser_data    = 1'b0;
    ser_load    = 1'b1;
    model       = '{presc: 1'b0, ref_r: 14'd8, main_r: '0, swal_r: '0};
    model_err   = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(1);
    check_all("R1 reset values");
    check(load_strobe == 1'b0, "R1 strobe low after reset", 64'(load_strobe), 64'd0);
    // Load already high at reset release: no transfer expected
    wait_cyc(10);
    check(n_strobes == 0, "R5 idle-high load gives no transfer", 64'(n_strobes), 64'd0);
    ser_load = 1'b0;
    wait_cyc(6);

    fb_word(11'h5A3, 7'h2C, 1'b0, 6, "R4 feedback word");
    // The upper 3 bits of the shifter still hold feedback bits here (R3)
    ref_word(1'b1, 14'h1234, 1'b0, 6, "R3 reference word, leftovers ignored");
    ref_word(1'b0, 14'd7, 1'b0, 6, "R7 ratio 7 refused");
    fb_word(11'h7FF, 7'h7F, 1'b0, 6, "R4 max feedback, err stays set R7");
    ref_word(1'b1, 14'd0, 1'b0, 6, "R7 ratio 0 refused");
    ref_word(1'b0, 14'd8, 1'b0, 6, "R7 ratio 8 accepted, err cleared");
    ref_word(1'b1, 14'h3FFF, 1'b0, 40, "R5 long load high gives one transfer");
    fb_word(11'd16, 7'd1, 1'b1, 6, "R8 coincident feedback word");
    ref_word(1'b1, 14'h2222, 1'b1, 6, "R8 coincident reference word");
    fb_word(11'h2AA, 7'h55, 1'b0, 6, "R2 alternating bit pattern");

    wait_cyc(5);
    check(n_strobes == exp_strobes, "R6 strobe count", 64'(n_strobes), 64'(exp_strobes));
    check(exp_q.size() == 0, "R6 all expected transfers seen", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule